// File: doc/BRIEF.md
# Parallel ADC Host Interface Controller

This block is the host side of a link to a 12-bit sampling converter that presents its result on an 8-bit parallel bus. On a conversion request it pulses the active-low convert-start line, waits for the converter's busy flag to go high and then low again, and then fetches the result in two byte reads. A dedicated byte-select line picks the half, and chip-select and read strobes frame each access. The two bytes are merged into one 12-bit sample, which appears with a single-cycle valid pulse.

The same bus timing engine also performs single-byte writes into the converter's registers. Every interval is a count of system-clock cycles taken from configuration inputs: the convert-start width, the byte-select setup before a strobe, the strobe width, the byte-select hold after a strobe, and the idle gap after each access. A count of zero behaves as one cycle. If busy does not go high within a programmed number of cycles after convert-start is released, the controller abandons the conversion and raises a one-cycle timeout flag.

The busy input is asynchronous to the system clock and passes through a synchronizer of configurable depth. While an operation is in progress the controller ignores new requests.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, convert-start, chip-select, read and write strobes are all high (inactive), the data bus drive enable is low, and sample_valid and busy_timeout are low.
- R2: Each accepted conversion request drives adc_convst_n low for exactly max(cfg_conv_cyc,1) consecutive cycles, exactly once, and only when the controller was idle.
- R3: No read strobe is issued for a conversion until busy has been seen high and then low again, and the read strobe is never low while busy is high.
- R4: Byte-select keeps its value for at least max(cfg_setup_cyc,1) cycles before any read or write strobe falls. It stays unchanged while the strobe is low and for at least max(cfg_hold_cyc,1) cycles after the strobe rises.
- R5: Each read or write strobe stays low for exactly max(cfg_strobe_cyc,1) cycles, and adc_cs_n is low in exactly those cycles.
- R6: A conversion is followed by exactly two reads. The first read has byte-select low (0) and the second has byte-select high (1). The strobe is high for exactly max(hold,1)+max(gap,1)+max(setup,1) cycles between the two reads.
- R7: sample_data equals {bits 3..0 of the second byte, first byte}, and the top 4 bits of the second byte are ignored. sample_valid pulses high for one cycle per completed conversion, and sample_data changes only together with that pulse.
- R8: If synchronized busy is not seen high within max(cfg_timeout_cyc,1) cycles after convert-start rises, busy_timeout pulses for one cycle and the controller returns to idle with no reads. The pulse is seen in cycle max(cfg_timeout_cyc,1)+1, where the cycle in which convert-start is first high counts as cycle 1.
- R9: A write request performs one write strobe with byte-select equal to wr_high, and adc_dout equal to wr_byte with adc_dout_en high from setup through hold. The read strobe stays high, and the bus is never driven during a read.
- R10: Requests are taken only while ctrl_idle is high. A conversion request takes priority over a write request presented in the same cycle, and requests made during an operation are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_conv_cyc | input | CNT_W | Convert-start low width in cycles |
| cfg_setup_cyc | input | CNT_W | Byte-select setup before a strobe |
| cfg_strobe_cyc | input | CNT_W | Read/write strobe low width |
| cfg_hold_cyc | input | CNT_W | Byte-select hold after a strobe |
| cfg_gap_cyc | input | CNT_W | Idle gap after each access |
| cfg_timeout_cyc | input | TO_W | Busy-rise timeout in cycles |
| conv_req | input | 1 | Request a conversion and readout |
| wr_req | input | 1 | Request a register byte write |
| wr_high | input | 1 | Byte-select level for the write |
| wr_byte | input | BUS_W | Byte to write |
| ctrl_idle | output | 1 | Controller accepts requests |
| sample_data | output | DATA_W | Assembled conversion result |
| sample_valid | output | 1 | One-cycle pulse with a new result |
| busy_timeout | output | 1 | One-cycle pulse on a busy timeout |
| adc_convst_n | output | 1 | Convert-start strobe, active low |
| adc_busy | input | 1 | Converter busy flag, asynchronous |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_hbsel | output | 1 | Byte-select: 0 low byte, 1 high byte |
| adc_dout | output | BUS_W | Write data to the bus |
| adc_dout_en | output | 1 | Bus drive enable for writes |
| adc_din | input | BUS_W | Read data from the bus |

## Verification
The bench measures every strobe, setup, hold and gap interval as an exact cycle count, with all counts at zero as well as at random values. A controller that mishandles a zero count would either stall or stretch that phase. It uses a converter model whose busy rise is delayed and whose second byte carries junk in its upper nibble. A design that reads before busy falls, swaps the two bytes, or keeps the upper nibble would produce a wrong sample. A silent converter must give exactly one timeout pulse in the right cycle and no reads. Requests made mid-operation, and a conversion and a write requested together, must not start a second operation or a stray write.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_GAP
  } host_st_e;
endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         sat;

  assign sat  = &cnt_q;
  assign last = ({1'b0, cnt_q} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit};

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (!sat) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_byte_merge.sv
module adc_byte_merge #(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cap_hi,
  input  logic [BUS_W-1:0]  byte_in,
  input  logic              publish,
  output logic [DATA_W-1:0] result,
  output logic              valid
);
  localparam int HI_W = DATA_W - BUS_W;

  logic [BUS_W-1:0]  lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] res_q;
  logic              val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cap_en) begin
      if (cap_hi) hi_q <= byte_in[HI_W-1:0];
      else        lo_q <= byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      val_q <= 1'b0;
    end else begin
      val_q <= publish;
      if (publish) res_q <= {hi_q, lo_q};
    end
  end

  assign result = res_q;
  assign valid  = val_q;
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BUS_W       = 8,
  parameter int CNT_W       = 8,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_conv_cyc,
  input  logic [CNT_W-1:0]  cfg_setup_cyc,
  input  logic [CNT_W-1:0]  cfg_strobe_cyc,
  input  logic [CNT_W-1:0]  cfg_hold_cyc,
  input  logic [CNT_W-1:0]  cfg_gap_cyc,
  input  logic [TO_W-1:0]   cfg_timeout_cyc,
  input  logic              conv_req,
  input  logic              wr_req,
  input  logic              wr_high,
  input  logic [BUS_W-1:0]  wr_byte,
  output logic              ctrl_idle,
  output logic [DATA_W-1:0] sample_data,
  output logic              sample_valid,
  output logic              busy_timeout,
  output logic              adc_convst_n,
  input  logic              adc_busy,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic              adc_wr_n,
  output logic              adc_hbsel,
  output logic [BUS_W-1:0]  adc_dout,
  output logic              adc_dout_en,
  input  logic [BUS_W-1:0]  adc_din
);
  localparam int TW = (TO_W > CNT_W) ? TO_W : CNT_W;

  host_st_e         state_q, state_d;
  logic             op_wr_q, op_wr_d;
  logic             hi_q, hi_d;
  logic [BUS_W-1:0] wdata_q, wdata_d;
  logic             err_d, err_q;
  logic             cap_en, publish;
  logic             busy_s;
  logic             ph_last;
  logic [TW-1:0]    ph_limit;

  // busy synchronizer
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign busy_s = adc_busy;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], adc_busy};
      end
      assign busy_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    ph_limit = '0;
    unique case (state_q)
      ST_CONV:    ph_limit = TW'(cfg_conv_cyc);
      ST_WAIT_HI: ph_limit = TW'(cfg_timeout_cyc);
      ST_SETUP:   ph_limit = TW'(cfg_setup_cyc);
      ST_STROBE:  ph_limit = TW'(cfg_strobe_cyc);
      ST_HOLD:    ph_limit = TW'(cfg_hold_cyc);
      ST_GAP:     ph_limit = TW'(cfg_gap_cyc);
      default:    ph_limit = '0;
    endcase
  end

  adc_phase_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .limit   (ph_limit),
    .last    (ph_last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    op_wr_d = op_wr_q;
    hi_d    = hi_q;
    wdata_d = wdata_q;
    err_d   = 1'b0;
    cap_en  = 1'b0;
    publish = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (conv_req) begin
          state_d = ST_CONV;
          op_wr_d = 1'b0;
        end else if (wr_req) begin
          state_d = ST_SETUP;
          op_wr_d = 1'b1;
          hi_d    = wr_high;
          wdata_d = wr_byte;
        end
      end
      ST_CONV:    if (ph_last) state_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (busy_s) state_d = ST_WAIT_LO;
        else if (ph_last) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_WAIT_LO: begin
        if (!busy_s) begin
          state_d = ST_SETUP;
          hi_d    = 1'b0;
        end
      end
      ST_SETUP:   if (ph_last) state_d = ST_STROBE;
      ST_STROBE: begin
        if (ph_last) begin
          state_d = ST_HOLD;
          cap_en  = !op_wr_q;
        end
      end
      ST_HOLD:    if (ph_last) state_d = ST_GAP;
      ST_GAP: begin
        if (ph_last) begin
          if (!op_wr_q && !hi_q) begin
            state_d = ST_SETUP;
            hi_d    = 1'b1;
          end else begin
            state_d = ST_IDLE;
            publish = !op_wr_q;
          end
        end
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  // state and pin registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      op_wr_q      <= 1'b0;
      hi_q         <= 1'b0;
      wdata_q      <= '0;
      err_q        <= 1'b0;
      adc_convst_n <= 1'b1;
      adc_cs_n     <= 1'b1;
      adc_rd_n     <= 1'b1;
      adc_wr_n     <= 1'b1;
      adc_hbsel    <= 1'b0;
      adc_dout_en  <= 1'b0;
    end else begin
      state_q      <= state_d;
      op_wr_q      <= op_wr_d;
      hi_q         <= hi_d;
      wdata_q      <= wdata_d;
      err_q        <= err_d;
      adc_convst_n <= (state_d != ST_CONV);
      adc_cs_n     <= (state_d != ST_STROBE);
      adc_rd_n     <= !((state_d == ST_STROBE) && !op_wr_d);
      adc_wr_n     <= !((state_d == ST_STROBE) && op_wr_d);
      adc_hbsel    <= hi_d;
      adc_dout_en  <= op_wr_d && ((state_d == ST_SETUP) || (state_d == ST_STROBE) ||
                                  (state_d == ST_HOLD));
    end
  end

  adc_byte_merge #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .cap_hi  (hi_q),
    .byte_in (adc_din),
    .publish (publish),
    .result  (sample_data),
    .valid   (sample_valid)
  );

  assign adc_dout     = wdata_q;
  assign busy_timeout = err_q;
  assign ctrl_idle    = (state_q == ST_IDLE);
endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_idle,
  input logic [DATA_W-1:0] sample_data,
  input logic              sample_valid,
  input logic              busy_timeout,
  input logic              adc_convst_n,
  input logic              adc_busy,
  input logic              adc_cs_n,
  input logic              adc_rd_n,
  input logic              adc_wr_n,
  input logic              adc_hbsel,
  input logic              adc_dout_en
);
  a_r2_convst_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_convst_n) |-> $past(ctrl_idle));
  a_r3_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_busy);
  a_r4_hbsel_steady_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_hbsel));
  a_r5_cs_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_rd_n || !adc_wr_n) |-> !adc_cs_n);
  a_r5_strobe_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> (!adc_rd_n || !adc_wr_n));
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  a_r7_data_moves_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_data) |-> sample_valid);
  a_r8_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy_timeout |=> !busy_timeout);
  a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_rd_n && !adc_wr_n));
  a_r9_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_wr_n |-> adc_dout_en);
  a_r9_quiet_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_dout_en);
  a_r10_idle_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_idle |-> (adc_convst_n && adc_cs_n));
endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_idle    (ctrl_idle),
  .sample_data  (sample_data),
  .sample_valid (sample_valid),
  .busy_timeout (busy_timeout),
  .adc_convst_n (adc_convst_n),
  .adc_busy     (adc_busy),
  .adc_cs_n     (adc_cs_n),
  .adc_rd_n     (adc_rd_n),
  .adc_wr_n     (adc_wr_n),
  .adc_hbsel    (adc_hbsel),
  .adc_dout_en  (adc_dout_en)
);

// File: tb/adc_host_ctrl_test.sv
module adc_host_ctrl_test;
  logic        clk, rst_n;
  logic [7:0]  c_conv, c_setup, c_strobe, c_hold, c_gap;
  logic [15:0] c_tout;
  logic        conv_req, wr_req, wr_high;
  logic [7:0]  wr_byte;
  logic        ctrl_idle, sample_valid, busy_timeout;
  logic [11:0] sample_data;
  logic        adc_convst_n, adc_busy, adc_cs_n, adc_rd_n, adc_wr_n, adc_hbsel, adc_dout_en;
  logic [7:0]  adc_dout, adc_din;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  // converter model state
  logic [11:0] m_res;
  int  m_dly, m_len, m_t;
  bit  m_act, m_mute, m_busy_done;
  // expected interval lengths
  int  e_conv, e_setup, e_strobe, e_hold, e_gap, e_tout;
  logic [7:0] e_wbyte; logic e_whigh;
  // monitor state
  bit  p_cv, p_rd, p_wr, p_hb, strobed;
  int  conv_low, rd_low, wr_low, rd_high, hb_stable, since_rise, since_cv;
  int  n_conv, n_reads, n_writes, n_valid, n_err;

  adc_host_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_conv_cyc(c_conv), .cfg_setup_cyc(c_setup), .cfg_strobe_cyc(c_strobe),
    .cfg_hold_cyc(c_hold), .cfg_gap_cyc(c_gap), .cfg_timeout_cyc(c_tout),
    .conv_req(conv_req), .wr_req(wr_req), .wr_high(wr_high), .wr_byte(wr_byte),
    .ctrl_idle(ctrl_idle), .sample_data(sample_data), .sample_valid(sample_valid),
    .busy_timeout(busy_timeout), .adc_convst_n(adc_convst_n), .adc_busy(adc_busy),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n), .adc_hbsel(adc_hbsel),
    .adc_dout(adc_dout), .adc_dout_en(adc_dout_en), .adc_din(adc_din)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // read data: second byte carries junk in its upper nibble
  assign adc_din = (!adc_cs_n && !adc_rd_n) ? (adc_hbsel ? {4'hA, m_res[11:8]} : m_res[7:0]) : 8'h5C;

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // monitor and converter model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    if (rst_n) begin
      // R2 convert-start width
      if (!adc_convst_n) conv_low++;
      if (adc_convst_n && !p_cv) begin
        check(conv_low == e_conv, "R2 convst width", conv_low, e_conv);
        conv_low = 0; n_conv++; since_cv = 1;
      end else since_cv++;
      // read strobe
      if (!adc_rd_n && p_rd) begin
        check(m_busy_done, "R3 read after busy fell", int'(m_busy_done), 1);
        check(hb_stable >= e_setup, "R4 setup before read", hb_stable, e_setup);
        check(adc_hbsel == (n_reads != 0), "R6 byte order", int'(adc_hbsel), int'(n_reads != 0));
        if (n_reads == 1)
          check(rd_high == e_hold + e_gap + e_setup, "R6 gap between reads", rd_high, e_hold + e_gap + e_setup);
        n_reads++;
      end
      if (!adc_rd_n) begin rd_low++; rd_high = 0; end else rd_high++;
      if (adc_rd_n && !p_rd) begin
        check(rd_low == e_strobe, "R5 read width", rd_low, e_strobe);
        rd_low = 0;
      end
      // write strobe
      if (!adc_wr_n && p_wr) begin
        check(hb_stable >= e_setup, "R4 setup before write", hb_stable, e_setup);
        check(adc_rd_n, "R9 no read in write", int'(adc_rd_n), 1);
      end
      if (!adc_wr_n) wr_low++;
      if (adc_wr_n && !p_wr) begin
        check(wr_low == e_strobe, "R5 write width", wr_low, e_strobe);
        check(adc_dout_en && adc_dout == e_wbyte, "R9 write data", int'(adc_dout), int'(e_wbyte));
        check(adc_hbsel == e_whigh, "R9 write byte-select", int'(adc_hbsel), int'(e_whigh));
        wr_low = 0; n_writes++;
      end
      // byte-select hold
      if (adc_hbsel != p_hb) begin
        if (strobed) check(since_rise >= e_hold, "R4 hold after strobe", since_rise, e_hold);
        hb_stable = 1;
      end else hb_stable++;
      if ((adc_rd_n && !p_rd) || (adc_wr_n && !p_wr)) begin since_rise = 1; strobed = 1; end
      else since_rise++;
      // outputs
      if (sample_valid) begin
        n_valid++;
        check(sample_data == m_res, "R7 sample value", int'(sample_data), int'(m_res));
      end
      if (busy_timeout) begin
        n_err++;
        check(since_cv == e_tout + 1, "R8 timeout cycle", since_cv, e_tout + 1);
      end
      // model
      if (!adc_convst_n && p_cv) begin
        m_busy_done = 0;
        if (!m_mute) begin m_act = 1; m_t = 0; end
      end
      if (m_act) begin
        m_t++;
        adc_busy = (m_t > m_dly) && (m_t <= m_dly + m_len);
        if (m_t > m_dly + m_len) begin m_act = 0; adc_busy = 0; m_busy_done = 1; end
      end
    end
    p_cv = adc_convst_n; p_rd = adc_rd_n; p_wr = adc_wr_n; p_hb = adc_hbsel;
  end

  task automatic set_cfg(input int cv, input int su, input int st, input int ho, input int ga, input int to);
    c_conv = 8'(cv); c_setup = 8'(su); c_strobe = 8'(st); c_hold = 8'(ho); c_gap = 8'(ga);
    c_tout = 16'(to);
    e_conv = mx1(cv); e_setup = mx1(su); e_strobe = mx1(st); e_hold = mx1(ho);
    e_gap = mx1(ga); e_tout = mx1(to);
  endtask

  task automatic clear_counts();
    n_conv = 0; n_reads = 0; n_writes = 0; n_valid = 0; n_err = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (!ctrl_idle && guard < 5000) begin @(negedge clk); guard++; end
    check(guard < 5000, "R10 returns to idle", guard, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_conv(input logic [11:0] res, input bit mute, input bit poke);
    clear_counts();
    m_res = res; m_mute = mute;
    conv_req = 1; @(negedge clk); conv_req = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      conv_req = 1; wr_req = 1; @(negedge clk); conv_req = 0; wr_req = 0;
    end
    wait_idle();
    if (mute) begin
      check(n_err == 1, "R8 timeout count", n_err, 1);
      check(n_reads == 0, "R8 no reads", n_reads, 0);
      check(n_valid == 0, "R8 no sample", n_valid, 0);
    end else begin
      check(n_conv == 1, "R2 one convst", n_conv, 1);
      check(n_reads == 2, "R6 two reads", n_reads, 2);
      check(n_valid == 1, "R7 one valid", n_valid, 1);
      check(n_err == 0, "R8 no timeout", n_err, 0);
      check(n_writes == 0, "R10 no write", n_writes, 0);
    end
  endtask

  task automatic do_write(input logic [7:0] b, input logic hb);
    clear_counts();
    e_wbyte = b; e_whigh = hb; wr_byte = b; wr_high = hb;
    wr_req = 1; @(negedge clk); wr_req = 0;
    wait_idle();
    check(n_writes == 1, "R9 one write", n_writes, 1);
    check(n_reads == 0 && n_conv == 0, "R9 no read or convst", n_reads + n_conv, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd13579);
    rst_n = 0; conv_req = 0; wr_req = 0; wr_high = 0; wr_byte = 0; adc_busy = 0;
    m_res = 0; m_dly = 1; m_len = 12; m_t = 0; m_act = 0; m_mute = 0; m_busy_done = 0;
    conv_low = 0; rd_low = 0; wr_low = 0; rd_high = 0; hb_stable = 0; since_rise = 0;
    since_cv = 0; strobed = 0; p_cv = 1; p_rd = 1; p_wr = 1; p_hb = 0;
    e_wbyte = 0; e_whigh = 0;
    clear_counts();
    set_cfg(2, 2, 3, 2, 2, 12);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(adc_convst_n && adc_cs_n && adc_rd_n && adc_wr_n, "R1 strobes idle", 0, 1);
    check(!adc_dout_en && !sample_valid && !busy_timeout, "R1 outputs quiet", 0, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(ctrl_idle, "R1 idle after reset", int'(ctrl_idle), 1);

    // directed: all counts zero, then a write and both byte-select levels
    set_cfg(0, 0, 0, 0, 0, 0 + 10);
    m_dly = 0; m_len = 11;
    do_conv(12'hABC, 0, 0);
    do_write(8'h3E, 1);
    do_write(8'hC1, 0);
    // directed: R10 requests mid-operation and conv+write together
    set_cfg(3, 1, 2, 1, 4, 16);
    m_dly = 2; m_len = 15;
    do_conv(12'h5A7, 0, 1);
    clear_counts();
    m_res = 12'h0F0; m_mute = 0;
    wr_byte = 8'h77; wr_high = 1;
    conv_req = 1; wr_req = 1; @(negedge clk); conv_req = 0; wr_req = 0;
    wait_idle();
    check(n_conv == 1 && n_writes == 0, "R10 convert wins", n_writes, 0);
    // directed: R8 silent converter
    set_cfg(1, 1, 1, 1, 1, 9);
    do_conv(12'h123, 1, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int sel;
      set_cfg($urandom_range(0, 8), $urandom_range(0, 5), $urandom_range(0, 5),
              $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(8, 20));
      m_dly = $urandom_range(0, 3); m_len = $urandom_range(12, 25);
      sel = $urandom_range(0, 9);
      if (sel < 7)      do_conv(12'($urandom), 0, 0);
      else if (sel < 9) do_write(8'($urandom), 1'($urandom));
      else              do_conv(12'($urandom), 1, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule